// File: doc/BRIEF.md
# Integer ALU with Shifter

This block is the combinational integer execution unit of a load/store RISC core. Each cycle it takes two 32-bit operands, a 5-bit constant shift count and a 5-bit operation code, and produces a 32-bit result together with an overflow flag that the surrounding pipeline turns into an exception. Immediates are sign- or zero-extended before they reach the operand port. Multiply, divide and register-file access are handled elsewhere.

The unit has four datapaths side by side: an adder/subtractor, a comparator for signed and unsigned less-than, a bitwise logic unit that also forms the upper-immediate value, and a logarithmic barrel shifter. The operation code selects one result. Variable shifts take their count from the low five bits of operand A. Constant shifts take it from the shift-count port.

Top module: `int_exec_unit`

Operation codes (value of `op_sel`): 0 add trapping, 1 add wrapping, 2 subtract trapping, 3 subtract wrapping, 4 signed less-than, 5 unsigned less-than, 6 AND, 7 OR, 8 XOR, 9 NOR, 10 upper immediate, 11 shift left by `shamt`, 12 logical right by `shamt`, 13 arithmetic right by `shamt`, 14 shift left by `opa[4:0]`, 15 logical right by `opa[4:0]`, 16 arithmetic right by `opa[4:0]`. Codes 17 to 31 are unused. Shifted data always comes from `opb`.

## Requirements
- R1: Code 0 returns (opa + opb) mod 2^32, and `ovf` is 1 exactly when opa and opb have the same bit 31 and the sum's bit 31 differs from it.
- R2: Codes 1 and 3 return the same result bits as codes 0 and 2 for the same operands, and `ovf` is 0 for both.
- R3: Code 2 returns (opa - opb) mod 2^32, and `ovf` is 1 exactly when opa and opb differ in bit 31 and the difference's bit 31 differs from opa's bit 31.
- R4: Code 4 returns 1 when opa < opb as signed two's-complement values, else 0. Code 5 compares them as unsigned. Bits 31:1 are zero.
- R5: Codes 6, 7, 8 and 9 return the bitwise AND, OR, XOR and NOR of opa and opb. For example, NOR of 0xFF00FF00 and 0xF0F0F0F0 gives 0x000F000F.
- R6: Code 10 returns opb[15:0] in bits 31:16 and zero in bits 15:0.
- R7: Codes 11 and 12 shift opb left or right by `shamt` and fill the vacated bits with zeros. Count 0 returns opb unchanged.
- R8: Codes 13 and 16 shift opb right and fill the vacated high bits with copies of opb[31].
- R9: Codes 14, 15 and 16 use only opa[4:0] as the count. opa[31:5] and the `shamt` port have no effect on the result.
- R10: `ovf` is 0 for every code other than 0 and 2.
- R11: Codes 17 to 31 return a zero result with `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand; low 5 bits are the count for variable shifts |
| opb | input | 32 | Second operand; the data that shifts and the upper-immediate act on |
| shamt | input | 5 | Count for constant shifts |
| op_sel | input | 5 | Operation code |
| result | output | 32 | Selected result |
| ovf | output | 1 | Two's-complement overflow of a trapping add or subtract |

## Verification
The checker's immediate assertions assume that all inputs are known values and that they are read once the combinational paths have settled. The bench meets both conditions: it changes inputs right after a rising edge and reads outputs at the falling edge. Random operands are drawn across the full 32-bit range, including codes 17 to 31. Directed cases add the sign-boundary operands 0x7FFFFFFF and 0x80000000, counts of 0 and 31, and variable-shift counts whose upper bits and `shamt` value are deliberately nonzero, so that every assertion premise is reached.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD_TRAP  = 5'd0,
        OP_ADD_WRAP  = 5'd1,
        OP_SUB_TRAP  = 5'd2,
        OP_SUB_WRAP  = 5'd3,
        OP_LT_SIGNED = 5'd4,
        OP_LT_UNSIGN = 5'd5,
        OP_AND       = 5'd6,
        OP_OR        = 5'd7,
        OP_XOR       = 5'd8,
        OP_NOR       = 5'd9,
        OP_UPPER_IMM = 5'd10,
        OP_SHL_K     = 5'd11,
        OP_SHRL_K    = 5'd12,
        OP_SHRA_K    = 5'd13,
        OP_SHL_V     = 5'd14,
        OP_SHRL_V    = 5'd15,
        OP_SHRA_V    = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        LOGIC_AND = 2'd0,
        LOGIC_OR  = 2'd1,
        LOGIC_XOR = 2'd2,
        LOGIC_NOR = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         sgn_ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = subtract ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, subtract};
        // Overflow when the effective operands agree in sign but the sum does not.
        sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    output logic         less
);
    localparam int MSB = W - 1;

    logic ult;

    always_comb begin
        ult = (a < b);
        // Signed order equals unsigned order with the sign bits inverted.
        if (is_signed && (a[MSB] != b[MSB]))
            less = a[MSB];
        else
            less = ult;
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]               a,
    input  logic [W-1:0]               b,
    input  alu_pkg::logic_fn_e         fn,
    output logic [W-1:0]               y
);
    import alu_pkg::*;

    always_comb begin
        unique case (fn)
            LOGIC_AND: y = a & b;
            LOGIC_OR:  y = a | b;
            LOGIC_XOR: y = a ^ b;
            LOGIC_NOR: y = ~(a | b);
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           to_left,
    input  logic           arith,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage [SHW+1];
    logic [W-1:0] din_rev;
    logic [W-1:0] last_rev;
    logic         fill;

    assign fill = arith & ~to_left & din[W-1];

    // A left shift is a right shift of the bit-reversed word.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din_rev[i]  = din[W-1-i];
        assign last_rev[i] = stage[SHW][W-1-i];
    end

    assign stage[0] = to_left ? din_rev : din;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
    end

    assign dout = to_left ? last_rev : stage[SHW];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int W     = 32,
    parameter int SHW   = $clog2(W),
    parameter int OPW   = 5,
    parameter int IMMW  = W / 2
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [SHW-1:0] shamt,
    input  logic [OPW-1:0] op_sel,
    output logic [W-1:0]   result,
    output logic           ovf
);
    import alu_pkg::*;

    localparam int LOW_ZERO = W - IMMW;

    alu_op_e   op;
    logic      do_sub;
    logic      cmp_signed;
    logic_fn_e lfn;
    logic      sh_left;
    logic      sh_arith;
    logic      sh_var;
    logic [SHW-1:0] sh_amt;

    logic [W-1:0] as_sum;
    logic         as_ovf;
    logic         cmp_less;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_y;
    logic [W-1:0] upper_imm;

    assign op = alu_op_e'(op_sel);

    // Decode of datapath controls.
    always_comb begin
        do_sub     = (op == OP_SUB_TRAP) || (op == OP_SUB_WRAP);
        cmp_signed = (op == OP_LT_SIGNED);
        sh_left    = (op == OP_SHL_K) || (op == OP_SHL_V);
        sh_arith   = (op == OP_SHRA_K) || (op == OP_SHRA_V);
        sh_var     = (op == OP_SHL_V) || (op == OP_SHRL_V) || (op == OP_SHRA_V);
        sh_amt     = sh_var ? opa[SHW-1:0] : shamt;
        case (op)
            OP_AND:  lfn = LOGIC_AND;
            OP_OR:   lfn = LOGIC_OR;
            OP_XOR:  lfn = LOGIC_XOR;
            default: lfn = LOGIC_NOR;
        endcase
    end

    assign upper_imm = {opb[IMMW-1:0], {LOW_ZERO{1'b0}}};

    alu_addsub #(.W(W)) u_addsub (
        .a        (opa),
        .b        (opb),
        .subtract (do_sub),
        .sum      (as_sum),
        .sgn_ovf  (as_ovf)
    );

    alu_compare #(.W(W)) u_cmp (
        .a         (opa),
        .b         (opb),
        .is_signed (cmp_signed),
        .less      (cmp_less)
    );

    alu_logic #(.W(W)) u_logic (
        .a  (opa),
        .b  (opb),
        .fn (lfn),
        .y  (logic_y)
    );

    alu_shifter #(.W(W), .SHW(SHW)) u_shift (
        .din     (opb),
        .amt     (sh_amt),
        .to_left (sh_left),
        .arith   (sh_arith),
        .dout    (shift_y)
    );

    // Result select.
    always_comb begin
        result = '0;
        ovf    = 1'b0;
        case (op)
            OP_ADD_TRAP, OP_SUB_TRAP: begin
                result = as_sum;
                ovf    = as_ovf;
            end
            OP_ADD_WRAP, OP_SUB_WRAP:     result = as_sum;
            OP_LT_SIGNED, OP_LT_UNSIGN:   result = {{(W-1){1'b0}}, cmp_less};
            OP_AND, OP_OR, OP_XOR, OP_NOR: result = logic_y;
            OP_UPPER_IMM:                 result = upper_imm;
            OP_SHL_K, OP_SHRL_K, OP_SHRA_K,
            OP_SHL_V, OP_SHRL_V, OP_SHRA_V: result = shift_y;
            default: begin
                result = '0;
                ovf    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
    parameter int W   = 32,
    parameter int OPW = 5
) (
    input logic [W-1:0]   opa,
    input logic [W-1:0]   opb,
    input logic [OPW-1:0] op_sel,
    input logic [W-1:0]   result,
    input logic           ovf
);
    localparam int MSB = W - 1;

    always_comb begin
        // R10: the flag appears only for trapping add and subtract.
        a_r10_ovf_only_trap: assert (!ovf || op_sel == 5'd0 || op_sel == 5'd2)
            else $error("ovf raised for op %0d", op_sel);
        // R1: overflow on add needs operands of equal sign.
        if (op_sel == 5'd0 && ovf)
            a_r1_add_ovf_signs: assert (opa[MSB] == opb[MSB] && result[MSB] != opa[MSB])
                else $error("add overflow with inconsistent signs");
        // R3: overflow on subtract needs operands of different sign.
        if (op_sel == 5'd2 && ovf)
            a_r3_sub_ovf_signs: assert (opa[MSB] != opb[MSB] && result[MSB] != opa[MSB])
                else $error("sub overflow with inconsistent signs");
        // R4: comparisons give a single bit.
        if (op_sel == 5'd4 || op_sel == 5'd5)
            a_r4_lt_is_bit: assert (result[W-1:1] == '0)
                else $error("compare result not 0/1");
        // R6: upper immediate leaves the low half empty.
        if (op_sel == 5'd10)
            a_r6_upper_low_zero: assert (result[W/2-1:0] == '0)
                else $error("upper immediate low half nonzero");
        // R11: unused codes give zero.
        if (op_sel > 5'd16)
            a_r11_unused_zero: assert (result == '0 && !ovf)
                else $error("unused op produced output");
    end
endmodule

bind int_exec_unit int_exec_unit_chk #(.W(W), .OPW(OPW)) u_chk (
    .opa    (opa),
    .opb    (opb),
    .op_sel (op_sel),
    .result (result),
    .ovf    (ovf)
);

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] opa, opb;
    logic [4:0]  shamt, op_sel;
    logic [31:0] result;
    logic        ovf;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_unit u0 (
        .opa(opa), .opb(opb), .shamt(shamt), .op_sel(op_sel),
        .result(result), .ovf(ovf)
    );

    function automatic logic [31:0] exp_res(input logic [4:0] o, input logic [31:0] a,
                                            input logic [31:0] b, input logic [4:0] s);
        case (o)
            5'd0, 5'd1: return a + b;
            5'd2, 5'd3: return a - b;
            5'd4:  return {31'd0, ($signed(a) < $signed(b))};
            5'd5:  return {31'd0, (a < b)};
            5'd6:  return a & b;
            5'd7:  return a | b;
            5'd8:  return a ^ b;
            5'd9:  return ~(a | b);
            5'd10: return {b[15:0], 16'h0000};
            5'd11: return b << s;
            5'd12: return b >> s;
            5'd13: return $unsigned($signed(b) >>> s);
            5'd14: return b << (a % 32);
            5'd15: return b >> (a % 32);
            5'd16: return $unsigned($signed(b) >>> (a % 32));
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (o == 5'd0) r = sa + sb;
        else if (o == 5'd2) r = sa - sb;
        else return 1'b0;
        return (r > 64'sd2147483647) || (r < -64'sd2147483648);
    endfunction

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd0: return "R1";
            5'd1, 5'd3: return "R2";
            5'd2: return "R3";
            5'd4, 5'd5: return "R4";
            5'd6, 5'd7, 5'd8, 5'd9: return "R5";
            5'd10: return "R6";
            5'd11, 5'd12: return "R7";
            5'd13: return "R8";
            5'd14, 5'd15, 5'd16: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] s, input string tag);
        logic [31:0] er;
        logic        eo;
        @(posedge clk);
        op_sel = o; opa = a; opb = b; shamt = s;
        er = exp_res(o, a, b, s);
        eo = exp_ovf(o, a, b);
        @(negedge clk);
        checks++;
        if (result !== er) begin
            errors++;
            $display("FAIL %s op=%0d result: actual %h expected %h", tag, o, result, er);
        end
        checks++;
        if (ovf !== eo) begin
            errors++;
            $display("FAIL %s/R10 op=%0d ovf: actual %0b expected %0b", tag, o, ovf, eo);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        logic [4:0]  ro, rs;
        void'($urandom(32'h5EED_1234));
        opa = '0; opb = '0; shamt = '0; op_sel = 5'd0;
        @(negedge clk);
        checks++;
        if (result !== 32'd0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1 initial zero inputs: actual %h/%0b expected 0/0", result, ovf);
        end
        // R1 add overflow boundaries
        apply(5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R1");
        apply(5'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, "R1");
        apply(5'd0, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R1");
        apply(5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R1");
        // R2 wrapping forms
        apply(5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R2");
        apply(5'd3, 32'h8000_0000, 32'h0000_0001, 5'd0, "R2");
        // R3 subtract overflow boundaries
        apply(5'd2, 32'h8000_0000, 32'h0000_0001, 5'd0, "R3");
        apply(5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R3");
        apply(5'd2, 32'h0000_0000, 32'h8000_0000, 5'd0, "R3");
        apply(5'd2, 32'h0000_0005, 32'h0000_0007, 5'd0, "R3");
        // R4 comparisons around sign
        apply(5'd4, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R4");
        apply(5'd5, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R4");
        apply(5'd4, 32'h0000_0003, 32'h0000_0003, 5'd0, "R4");
        apply(5'd5, 32'h0000_0002, 32'h8000_0000, 5'd0, "R4");
        // R5 NOR example and others
        apply(5'd9, 32'hFF00_FF00, 32'hF0F0_F0F0, 5'd0, "R5");
        apply(5'd6, 32'hFF00_FF00, 32'hF0F0_F0F0, 5'd0, "R5");
        apply(5'd8, 32'hFF00_FF00, 32'hF0F0_F0F0, 5'd0, "R5");
        // R6 upper immediate ignores opb high half
        apply(5'd10, 32'h1234_5678, 32'hABCD_C0DE, 5'd0, "R6");
        // R7 constant shifts, counts 0 and 31
        apply(5'd11, 32'h0, 32'h8000_0001, 5'd0, "R7");
        apply(5'd11, 32'h0, 32'h8000_0001, 5'd31, "R7");
        apply(5'd12, 32'h0, 32'h8000_0001, 5'd31, "R7");
        // R8 arithmetic right
        apply(5'd13, 32'h0, 32'h8000_0000, 5'd31, "R8");
        apply(5'd13, 32'h0, 32'h4000_0000, 5'd2, "R8");
        apply(5'd16, 32'h0000_0004, 32'hF000_0000, 5'd0, "R8");
        // R9 variable shifts use only opa[4:0]
        apply(5'd14, 32'hFFFF_FFE3, 32'h0000_0001, 5'd7, "R9");
        apply(5'd15, 32'h0000_0020, 32'h8000_0000, 5'd9, "R9");
        apply(5'd16, 32'hABCD_EF1F, 32'h8000_0000, 5'd1, "R9");
        // R11 unused codes
        apply(5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, "R11");
        apply(5'd31, 32'h7FFF_FFFF, 32'h0000_0001, 5'd3, "R11");
        // Random mix
        for (int i = 0; i < 2000; i++) begin
            ro = 5'($urandom_range(0, 31));
            ra = $urandom();
            rb = $urandom();
            rs = 5'($urandom());
            if (i % 4 == 0) begin
                ra[31] = ~rb[31] ^ (ro == 5'd2);
                ra[30:0] = 31'h7FFF_FF00 | 31'($urandom_range(0, 255));
            end
            apply(ro, ra, rb, rs, req_of(ro));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule